// File: doc/BRIEF.md
# Compare-Flag Branch and Jump Unit

This block owns the program counter of a 32-bit RISC core and decides, one instruction at a time, where execution goes next. A compare instruction tests a register value against a sign-extended immediate and records the result in two sticky status flags, equal and below. Six conditional branches then test those flags. Two register-indirect jumps load the program counter from a register, and one of them also produces a link write of the return address into register 31. A system-call instruction raises a trap request. Every other opcode simply advances the counter by one instruction (4 bytes).

The core presents each instruction on the `instr` bus with the already-read values of its two source registers and pulses `issue` for one cycle per instruction. The unit updates its program counter and flags on that clock edge. It offers the next address, the link write and the trap requests combinationally in the same cycle, so the surrounding pipeline can steer fetch, write the register file and start trap handling. The arithmetic unit, the data memory and the system-call handler sit outside this block. By convention, the handler takes the call number from register 1 and arguments from registers 2 to 9, and returns its result in register 2.

Top module: `flow_ctl_unit`

## Requirements
- R1: While reset is asserted and after it is released, the program counter reads 0 and both flags read 0 until the first issued instruction.
- R2: An issued instruction whose opcode (`instr[31:26]`) is not one of 24..30, 32, 33 or 56 advances the program counter by 4 at the clock edge. With `issue` low, the program counter and flags hold.
- R3: Compare (opcode 24) sets the equal flag to 1 exactly when `reg_b` equals the immediate `instr[15:0]` sign-extended to 32 bits.
- R4: Compare sets the below flag to 1 exactly when `reg_b` is unsigned-less-than the sign-extended immediate, so the two flags are never both 1.
- R5: Only an issued compare changes the flags. Branches, jumps, the system call and all other opcodes leave them unchanged.
- R6: The branch opcodes are taken on these conditions: 25 on equal, 26 on not equal, 27 on below, 28 on not below, 29 on equal or below, 30 on neither.
- R7: A taken branch moves the program counter to PC + 4 + 4 × sign-extended immediate. An untaken branch moves it to PC + 4.
- R8: Plain jump (opcode 32) loads the program counter with `reg_a` exactly, with no extra increment.
- R9: Jump-and-link (opcode 33) loads the program counter with `reg_a`. In the issue cycle it drives `link_we`=1, `link_idx`=31 and `link_data`=PC + 4. No other instruction asserts `link_we`.
- R10: A jump or jump-and-link whose `reg_a` has either of bits 1:0 set raises `unaligned_trap` in the issue cycle. It keeps the program counter unchanged and performs no link write.
- R11: The system call (opcode 56) raises `sys_trap` in the issue cycle and advances the program counter by 4.
- R12: `next_pc` always shows the value the program counter takes at the next edge if the current instruction is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue | input | 1 | One instruction is presented this cycle |
| instr | input | 32 | Instruction word; opcode in bits 31:26, immediate in bits 15:0 |
| reg_a | input | 32 | Value of source register a (jump target) |
| reg_b | input | 32 | Value of source register b (compare operand) |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Program counter after this instruction |
| flag_z | output | 1 | Equal flag |
| flag_n | output | 1 | Below flag (unsigned) |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index (31) |
| link_data | output | 32 | Return address written on link |
| sys_trap | output | 1 | System-call trap request |
| unaligned_trap | output | 1 | Misaligned jump target trap request |

## Verification
`next_pc`, `link_we`, `link_idx`, `link_data`, `sys_trap` and `unaligned_trap` are combinational and belong to the cycle in which `issue` is high. The bench drives each instruction just after a falling edge and samples these outputs 1 ns later, before the rising edge. The program counter and both flags are registered, so their new values are due one rising edge after the issue cycle. The bench samples them at the following falling edge, after it has dropped `issue`. Reset release passes through a two-stage synchronizer, and the bench waits several cycles after deassertion before the first check.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OP_CMP = 6'd24;
  localparam logic [OPC_W-1:0] OP_BEQ = 6'd25;
  localparam logic [OPC_W-1:0] OP_BNE = 6'd26;
  localparam logic [OPC_W-1:0] OP_BLT = 6'd27;
  localparam logic [OPC_W-1:0] OP_BGE = 6'd28;
  localparam logic [OPC_W-1:0] OP_BLE = 6'd29;
  localparam logic [OPC_W-1:0] OP_BGT = 6'd30;
  localparam logic [OPC_W-1:0] OP_JMP = 6'd32;
  localparam logic [OPC_W-1:0] OP_JAL = 6'd33;
  localparam logic [OPC_W-1:0] OP_SYS = 6'd56;

  // decoded class of the current instruction
  typedef enum logic [2:0] {
    K_SEQ,
    K_CMP,
    K_BRANCH,
    K_JUMP,
    K_JLINK,
    K_SYSC
  } kind_e;

  function automatic kind_e classify(input logic [OPC_W-1:0] op);
    kind_e k;
    if (op == OP_CMP)                        k = K_CMP;
    else if (op >= OP_BEQ && op <= OP_BGT)   k = K_BRANCH;
    else if (op == OP_JMP)                   k = K_JUMP;
    else if (op == OP_JAL)                   k = K_JLINK;
    else if (op == OP_SYS)                   k = K_SYSC;
    else                                     k = K_SEQ;
    return k;
  endfunction

endpackage

// File: rtl/fcu_rst_sync.sv
module fcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/fcu_flags.sv
module fcu_flags #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_en,
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic            eq_q,
  output logic            lt_q
);

  logic eq_d;
  logic lt_d;

  always_comb begin
    eq_d = eq_q;
    lt_d = lt_q;
    if (cmp_en) begin
      eq_d = (lhs == rhs);
      lt_d = (lhs < rhs);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q <= 1'b0;
      lt_q <= 1'b0;
    end else if (cmp_en) begin
      eq_q <= eq_d;
      lt_q <= lt_d;
    end
  end

endmodule

// File: rtl/fcu_cond.sv
module fcu_cond
  import fcu_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  input  logic             is_branch,
  input  logic             eq,
  input  logic             lt,
  output logic             taken
);

  logic hit;

  always_comb begin
    unique case (op)
      OP_BEQ:  hit = eq;
      OP_BNE:  hit = ~eq;
      OP_BLT:  hit = lt;
      OP_BGE:  hit = ~lt;
      OP_BLE:  hit = eq | lt;
      OP_BGT:  hit = ~(eq | lt);
      default: hit = 1'b0;
    endcase
    taken = is_branch & hit;
  end

endmodule

// File: rtl/fcu_target.sv
module fcu_target #(
  parameter int XLEN        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] jump_base,
  input  logic [XLEN-1:0] offset_x,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_pc,
  output logic            misaligned
);

  localparam int ALIGN_W = $clog2(INSTR_BYTES);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic [XLEN-1:0] scaled_off;

  always_comb begin
    seq_pc     = pc_cur + STEP;
    scaled_off = offset_x << ALIGN_W;
    br_pc      = seq_pc + scaled_off;
  end

  generate
    if (ALIGN_W > 0) begin : g_align_chk
      assign misaligned = |jump_base[ALIGN_W-1:0];
    end else begin : g_no_align_chk
      assign misaligned = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
  import fcu_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          IMM_W       = 16,
  parameter int          REG_IDX_W   = 5,
  parameter int          LINK_REG    = 31,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_PC    = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue,
  input  logic [XLEN-1:0]      instr,
  input  logic [XLEN-1:0]      reg_a,
  input  logic [XLEN-1:0]      reg_b,
  output logic [XLEN-1:0]      pc,
  output logic [XLEN-1:0]      next_pc,
  output logic                 flag_z,
  output logic                 flag_n,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]      link_data,
  output logic                 sys_trap,
  output logic                 unaligned_trap
);

  localparam int EXT_W = XLEN - IMM_W;

  logic             rst_n_sync;
  logic [OPC_W-1:0] op;
  logic [XLEN-1:0]  imm_x;
  kind_e            kind;
  logic             is_branch;
  logic             is_jump_any;
  logic             br_taken;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  br_pc;
  logic             misaligned;
  logic [XLEN-1:0]  pc_q;
  logic [XLEN-1:0]  pc_d;
  logic             pc_en;

  fcu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // decode
  always_comb begin
    op          = instr[XLEN-1 -: OPC_W];
    imm_x       = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    kind        = classify(op);
    is_branch   = (kind == K_BRANCH);
    is_jump_any = (kind == K_JUMP) || (kind == K_JLINK);
  end

  fcu_flags #(.XLEN(XLEN)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .cmp_en (issue && (kind == K_CMP)),
    .lhs    (reg_b),
    .rhs    (imm_x),
    .eq_q   (flag_z),
    .lt_q   (flag_n)
  );

  fcu_cond u_cond (
    .op        (op),
    .is_branch (is_branch),
    .eq        (flag_z),
    .lt        (flag_n),
    .taken     (br_taken)
  );

  fcu_target #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_target (
    .pc_cur     (pc_q),
    .jump_base  (reg_a),
    .offset_x   (imm_x),
    .seq_pc     (seq_pc),
    .br_pc      (br_pc),
    .misaligned (misaligned)
  );

  // next program counter selection
  always_comb begin
    if (is_jump_any) begin
      next_pc = misaligned ? pc_q : reg_a;
    end else if (br_taken) begin
      next_pc = br_pc;
    end else begin
      next_pc = seq_pc;
    end
    pc_en = issue;
    pc_d  = next_pc;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  pc_q <= RESET_PC[XLEN-1:0];
    else if (pc_en)   pc_q <= pc_d;
  end

  // side outputs of the issue cycle
  always_comb begin
    link_we        = issue && (kind == K_JLINK) && !misaligned;
    link_idx       = REG_IDX_W'(LINK_REG);
    link_data      = seq_pc;
    sys_trap       = issue && (kind == K_SYSC);
    unaligned_trap = issue && is_jump_any && misaligned;
  end

  assign pc = pc_q;

endmodule

// File: rtl/fcu_checker.sv
module fcu_checker #(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 issue,
  input logic [XLEN-1:0]      instr,
  input logic [XLEN-1:0]      pc,
  input logic [XLEN-1:0]      next_pc,
  input logic                 flag_z,
  input logic                 flag_n,
  input logic                 link_we,
  input logic [REG_IDX_W-1:0] link_idx,
  input logic [XLEN-1:0]      link_data,
  input logic                 sys_trap,
  input logic                 unaligned_trap
);

  logic [5:0] op;
  logic       ctl_op;
  assign op     = instr[XLEN-1 -: 6];
  assign ctl_op = (op >= 6'd24 && op <= 6'd30) || op == 6'd32 || op == 6'd33 || op == 6'd56;

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(pc) && $stable(flag_z) && $stable(flag_n));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !ctl_op |=> pc == $past(pc) + 32'd4);

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_z && flag_n));

  p_flags_cmp_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op != 6'd24 |=> $stable(flag_z) && $stable(flag_n));

  p_link_jal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> issue && op == 6'd33 && link_idx == 5'd31 && link_data == pc + 32'd4);

  p_unaligned_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unaligned_trap |=> $stable(pc));

  p_unaligned_nolink_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unaligned_trap |-> !link_we);

  p_sys_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_trap |-> issue && op == 6'd56);

  p_next_pc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> pc == $past(next_pc));

endmodule

bind flow_ctl_unit fcu_checker #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W)) u_fcu_checker (
  .clk            (clk),
  .rst_n          (rst_n_sync),
  .issue          (issue),
  .instr          (instr),
  .pc             (pc),
  .next_pc        (next_pc),
  .flag_z         (flag_z),
  .flag_n         (flag_n),
  .link_we        (link_we),
  .link_idx       (link_idx),
  .link_data      (link_data),
  .sys_trap       (sys_trap),
  .unaligned_trap (unaligned_trap)
);

// File: tb/test_flow_ctl_unit.sv
`timescale 1ns/1ps
module test_flow_ctl_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [31:0] instr;
  logic [31:0] reg_a;
  logic [31:0] reg_b;
  logic [31:0] pc;
  logic [31:0] next_pc;
  logic        flag_z;
  logic        flag_n;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_data;
  logic        sys_trap;
  logic        unaligned_trap;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  logic [31:0] m_pc;
  logic        m_z;
  logic        m_n;

  always #10 clk = ~clk;

  flow_ctl_unit i_flow_ctl_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
    .reg_a(reg_a), .reg_b(reg_b), .pc(pc), .next_pc(next_pc),
    .flag_z(flag_z), .flag_n(flag_n), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data),
    .sys_trap(sys_trap), .unaligned_trap(unaligned_trap)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic do_reset;
    issue = 1'b0; instr = '0; reg_a = '0; reg_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_pc = 32'h0; m_z = 1'b0; m_n = 1'b0;
    chk(pc == 32'h0, "R1 pc after reset", pc, 32'h0);
    chk(flag_z == 1'b0, "R1 flag_z after reset", {31'b0, flag_z}, 32'h0);
    chk(flag_n == 1'b0, "R1 flag_n after reset", {31'b0, flag_n}, 32'h0);
  endtask

  // issue one instruction at a falling edge; check same-cycle and next-cycle results
  task automatic step(input logic [5:0] op, input logic [15:0] imm,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] ix;
    logic [31:0] e_next;
    bit          e_link;
    bit          e_sys;
    bit          e_una;
    bit          tk;
    ix     = {{16{imm[15]}}, imm};
    e_link = 0; e_sys = 0; e_una = 0;
    e_next = m_pc + 32'd4;
    tk = (op == 6'd25 &&  m_z) || (op == 6'd26 && !m_z) ||
         (op == 6'd27 &&  m_n) || (op == 6'd28 && !m_n) ||
         (op == 6'd29 && (m_z || m_n)) || (op == 6'd30 && !m_z && !m_n);
    if (tk) e_next = m_pc + 32'd4 + ix * 32'd4;
    if (op == 6'd32 || op == 6'd33) begin
      if (a[1:0] != 2'b00) begin
        e_una  = 1;
        e_next = m_pc;
      end else begin
        e_next = a;
        e_link = (op == 6'd33);
      end
    end
    if (op == 6'd56) e_sys = 1;

    issue = 1'b1;
    instr = {op, 5'd7, 5'd9, imm};
    reg_a = a;
    reg_b = b;
    #1;
    chk(next_pc == e_next, {tag, " R12 next_pc"}, next_pc, e_next);
    chk(link_we == e_link, {tag, " R9 link_we"}, {31'b0, link_we}, {31'b0, e_link});
    if (e_link) begin
      chk(link_idx == 5'd31, {tag, " R9 link_idx"}, {27'b0, link_idx}, 32'd31);
      chk(link_data == m_pc + 32'd4, {tag, " R9 link_data"}, link_data, m_pc + 32'd4);
    end
    chk(sys_trap == e_sys, {tag, " R11 sys_trap"}, {31'b0, sys_trap}, {31'b0, e_sys});
    chk(unaligned_trap == e_una, {tag, " R10 unaligned_trap"}, {31'b0, unaligned_trap}, {31'b0, e_una});

    if (op == 6'd24) begin
      m_z = (b == ix);
      m_n = (b < ix);
    end
    m_pc = e_next;

    @(negedge clk);
    issue = 1'b0;
    chk(pc == m_pc, {tag, " pc"}, pc, m_pc);
    chk(flag_z == m_z, {tag, " flag_z"}, {31'b0, flag_z}, {31'b0, m_z});
    chk(flag_n == m_n, {tag, " flag_n"}, {31'b0, flag_n}, {31'b0, m_n});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
    end
  end

  initial begin
    logic [31:0] bl [7];
    logic [15:0] il [5];
    logic [31:0] hold;
    bl = '{32'h0, 32'h5, 32'h6, 32'h0000_7FFF, 32'h0000_8000, 32'hFFFF_8000, 32'hFFFF_FFFF};
    il = '{16'h0000, 16'h0005, 16'h7FFF, 16'h8000, 16'hFFFF};

    do_reset();

    // R2: idle cycles hold everything
    repeat (3) @(negedge clk);
    chk(pc == 32'h0, "R2 idle hold pc", pc, 32'h0);

    // R2/R5: every non-control opcode advances by 4 and leaves the flags
    step(6'd24, 16'h0005, 32'h0, 32'h3, "R4 set below");
    for (int o = 0; o < 64; o++) begin
      if ((o >= 24 && o <= 30) || o == 32 || o == 33 || o == 56) continue;
      step(6'(o), 16'(o * 37), 32'h1234_0000 + 32'(o), 32'h5, "R2 R5 seq");
    end

    // R3/R4: compare sweep
    foreach (bl[i]) begin
      foreach (il[j]) begin
        step(6'd24, il[j], 32'h0, bl[i], "R3 R4 cmp");
      end
    end

    // R6/R7: all branches under each reachable flag state and several offsets
    for (int f = 0; f < 3; f++) begin
      for (int op = 25; op <= 30; op++) begin
        for (int k = 0; k < 3; k++) begin
          logic [15:0] off;
          off = (k == 0) ? 16'h0003 : (k == 1) ? 16'hFFFE : 16'h0000;
          step(6'd24, 16'h0005, 32'h0, (f == 0) ? 32'h5 : (f == 1) ? 32'h3 : 32'h7, "R5 cmp setup");
          step(6'(op), off, 32'h0, 32'h0, "R6 R7 branch");
        end
      end
    end

    // R8: plain jump, aligned
    step(6'd32, 16'h0000, 32'h0000_4000, 32'h0, "R8 jump");
    step(6'd32, 16'h1234, 32'hFFFF_FFF0, 32'h0, "R8 jump high");
    // R9: jump and link
    step(6'd33, 16'h0000, 32'h0000_0100, 32'h0, "R9 jal");
    step(6'd33, 16'hFFFF, 32'h0000_0040, 32'h0, "R9 jal again");
    // R10: misaligned targets hold pc, no link
    hold = m_pc;
    step(6'd32, 16'h0000, 32'h0000_0203, 32'h0, "R10 jump misaligned");
    step(6'd33, 16'h0000, 32'h0000_0202, 32'h0, "R10 jal misaligned");
    step(6'd33, 16'h0000, 32'h0000_0201, 32'h0, "R10 jal misaligned b0");
    chk(pc == hold, "R10 pc unchanged", pc, hold);
    // R11: system call
    step(6'd56, 16'h0000, 32'h0, 32'h0, "R11 sys");
    step(6'd56, 16'hABCD, 32'h3, 32'h7, "R11 sys2");

    // R1: reset in mid-run returns to zero state
    step(6'd24, 16'h0009, 32'h0, 32'h9, "R3 eq before reset");
    do_reset();

    done = 1;
    report();
  end

endmodule